// File: doc/BRIEF.md
# Host Window to DSP Memory

This block gives a 16-bit host bus a narrow window into a DSP's local storage. The host never addresses memory directly. It loads a 32-bit cursor through two 16-bit registers and then moves words through a few data ports. A single linear address space holds both kinds of storage: 16-bit data words sit at low addresses, and 32-bit instruction words sit in a region selected by address bit 22.

An instruction word crosses the 16-bit bus in two halves. The low half goes first, through its own port, and is held in a staging register. The high half follows through the shared port and commits the whole word. An optional auto-increment lets the host stream blocks of data words or instruction words without reloading the cursor. A read-and-clear port hands back a data word and zeroes it in the same access, which suits mailbox-style flags.

The host presents one port select (`sel`) with a write strobe, a read strobe, or both, in a single clock cycle. Read data is registered.

Top module: `dsp_mem_window`

## Requirements
- R1: After reset the cursor is 0, auto-increment is off, `rdata` is 0, and every data-store and instruction-store location reads 0.
- R2: Port select codes are: 0 cursor bits 15..0, 1 cursor bits 31..16, 2 high/data port, 3 instruction low port, 4 read-and-clear port, 5 control. A write to 0 or 1 loads that cursor half, and a read returns it. Codes 6 and 7 read as 0 and ignore writes.
- R3: While cursor bit 22 is 0, the cursor is a data-store word address used without translation. Port 2 reads and writes the 16-bit word at that address.
- R4: While cursor bit 22 is 1, the instruction index is cursor bits 21..2. Port 3 reads bits 15..0 of that instruction word. Port 2 reads bits 31..16. A port 2 write stores the 32-bit word {wdata, staged low half}. In data space, port 3 reads 0.
- R5: Control bit 0 enables auto-increment, and a port 5 read returns it. When it is set, the cursor steps after any port 2 access and after a port 4 read. The step is 1 in data space and 4 in instruction space.
- R6: A port 3 access never moves the cursor. A port 3 write only stages the low half, and instruction memory is unchanged until the port 2 write that follows.
- R7: A port 4 read returns the data word at the cursor and leaves that location 0. In instruction space it returns 0 and changes no memory. Port 4 writes are ignored and do not step the cursor.
- R8: A data address at or above DS_DEPTH, an instruction index at or above IS_DEPTH, or an instruction-space cursor with any of bits 31..23 set reads as 0 and ignores writes.
- R9: `rdata` is updated on the clock edge of a read and holds otherwise. When read and write strobes hit port 2 together, `rdata` returns the prior content, the write takes effect, and the cursor steps once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 3 | Port select for this cycle |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |

## Verification
Two functions can fall in the same cycle: a read and a write to the high/data port, and a read-and-clear that also steps the cursor. The random stream sets both strobes together on a share of its accesses. The bench model then expects the pre-write content in `rdata`, the new word in memory, and exactly one cursor step. The result is judged by reading back the location and the cursor registers afterwards. Read-and-clear followed by a re-read at a rewound cursor shows the zero left behind.

// File: rtl/dsp_mem_window.sv
module dsp_mem_window #(
  parameter int DS_DEPTH = 256,
  parameter int IS_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  sel,
  input  logic        wr,
  input  logic        rd,
  input  logic [15:0] wdata,
  output logic [15:0] rdata
);
  localparam int DSW = $clog2(DS_DEPTH);
  localparam int ISW = $clog2(IS_DEPTH);
  localparam logic [2:0] P_ALO = 3'd0, P_AHI = 3'd1, P_DAT = 3'd2,
                         P_ILO = 3'd3, P_RAC = 3'd4, P_CTL = 3'd5;

  logic [15:0] ds_mem [DS_DEPTH];
  logic [31:0] is_mem [IS_DEPTH];
  logic [31:0] addr;
  logic [15:0] lo_buf;
  logic        autoinc;

  wire         is_sp  = addr[22];
  wire  [19:0] is_idx = addr[21:2];
  wire         ds_ok  = !is_sp && (addr < 32'(DS_DEPTH));
  wire         is_ok  = is_sp && (addr[31:23] == 9'd0) && (is_idx < 20'(IS_DEPTH));
  wire [DSW-1:0] ds_a = addr[DSW-1:0];
  wire [ISW-1:0] is_a = is_idx[ISW-1:0];
  wire  [15:0] ds_rd  = ds_ok ? ds_mem[ds_a] : 16'd0;
  wire  [31:0] is_rd  = is_ok ? is_mem[is_a] : 32'd0;

  wire step = autoinc && (((sel == P_DAT) && (rd || wr)) || ((sel == P_RAC) && rd));
  wire [31:0] next_addr = addr + (is_sp ? 32'd4 : 32'd1);

  logic [15:0] rd_mux;
  always_comb begin
    case (sel)
      P_ALO:   rd_mux = addr[15:0];
      P_AHI:   rd_mux = addr[31:16];
      P_DAT:   rd_mux = is_sp ? is_rd[31:16] : ds_rd;
      P_ILO:   rd_mux = is_sp ? is_rd[15:0] : 16'd0;
      P_RAC:   rd_mux = is_sp ? 16'd0 : ds_rd;
      P_CTL:   rd_mux = {15'd0, autoinc};
      default: rd_mux = 16'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr    <= '0;
      lo_buf  <= '0;
      autoinc <= 1'b0;
      rdata   <= '0;
    end else begin
      if (rd) rdata <= rd_mux;
      if (wr && sel == P_ALO) addr[15:0]  <= wdata;
      if (wr && sel == P_AHI) addr[31:16] <= wdata;
      if (wr && sel == P_ILO) lo_buf      <= wdata;
      if (wr && sel == P_CTL) autoinc     <= wdata[0];
      if (step) addr <= next_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DS_DEPTH; i++) ds_mem[i] <= '0;
    end else if (ds_ok) begin
      if (wr && sel == P_DAT)      ds_mem[ds_a] <= wdata;
      else if (rd && sel == P_RAC) ds_mem[ds_a] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < IS_DEPTH; i++) is_mem[i] <= '0;
    end else if (is_ok && wr && sel == P_DAT) begin
      is_mem[is_a] <= {wdata, lo_buf};
    end
  end
endmodule

module dsp_mem_window_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  sel,
  input logic        wr,
  input logic        rd,
  input logic [15:0] rdata,
  input logic [31:0] addr,
  input logic        autoinc
);
  wire acc = wr || rd;

  assert_lo_port_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && sel == 3'd3) |=> $stable(addr));

  assert_ds_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (autoinc && acc && sel == 3'd2 && !addr[22]) |=> (addr == $past(addr) + 32'd1));

  assert_is_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (autoinc && acc && sel == 3'd2 && addr[22]) |=> (addr == $past(addr) + 32'd4));

  assert_no_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!autoinc && acc && sel == 3'd2) |=> $stable(addr));

  assert_rac_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !rd && sel == 3'd4) |=> $stable(addr));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(addr) && $stable(rdata)));
endmodule

bind dsp_mem_window dsp_mem_window_chk chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd),
  .rdata(rdata), .addr(addr), .autoinc(autoinc)
);

// File: tb/dsp_mem_window_test.sv
module dsp_mem_window_test;
  localparam int DSD = 256;
  localparam int ISD = 64;

  logic clk = 0, rst_n = 0, wr = 0, rd = 0;
  logic [2:0] sel = 0;
  logic [15:0] wdata = 0, rdata;
  int n_chk = 0, n_bad = 0;

  logic [15:0] m_ds [DSD];
  logic [31:0] m_is [ISD];
  logic [31:0] m_addr;
  logic [15:0] m_lo;
  logic m_inc;

  dsp_mem_window #(.DS_DEPTH(DSD), .IS_DEPTH(ISD)) uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd),
    .wdata(wdata), .rdata(rdata));

  always #10 clk = ~clk;

  function automatic bit m_ds_ok();
    return !m_addr[22] && m_addr < DSD;
  endfunction
  function automatic bit m_is_ok();
    return m_addr[22] && m_addr[31:23] == 0 && m_addr[21:2] < ISD;
  endfunction

  function automatic logic [15:0] m_read(int s);
    logic [15:0] d = m_ds_ok() ? m_ds[m_addr[7:0]] : 16'd0;
    logic [31:0] q = m_is_ok() ? m_is[m_addr[7:2]] : 32'd0;
    case (s)
      0: return m_addr[15:0];
      1: return m_addr[31:16];
      2: return m_addr[22] ? q[31:16] : d;
      3: return m_addr[22] ? q[15:0] : 16'd0;
      4: return m_addr[22] ? 16'd0 : d;
      5: return {15'd0, m_inc};
      default: return 16'd0;
    endcase
  endfunction

  function automatic string tag_of(int s);
    if ((s == 2 || s == 3 || s == 4) && !m_ds_ok() && !m_is_ok()) return "R8";
    case (s)
      0, 1: return "R2";
      2: return m_addr[22] ? "R4" : "R3";
      3: return "R4";
      4: return "R7";
      5: return "R5";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string t, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic op(int s, bit w, bit r, logic [15:0] d);
    logic [15:0] exp;
    string t;
    bit stp;
    @(negedge clk);
    sel = 3'(s); wr = w; rd = r; wdata = d;
    exp = m_read(s);
    t = tag_of(s);
    stp = m_inc && ((s == 2 && (w || r)) || (s == 4 && r));
    if (w && s == 2 && m_ds_ok()) m_ds[m_addr[7:0]] = d;
    else if (r && s == 4 && m_ds_ok()) m_ds[m_addr[7:0]] = 16'd0;
    if (w && s == 2 && m_is_ok()) m_is[m_addr[7:2]] = {d, m_lo};
    if (w && s == 0) m_addr[15:0] = d;
    if (w && s == 1) m_addr[31:16] = d;
    if (w && s == 3) m_lo = d;
    if (w && s == 5) m_inc = d[0];
    if (stp) m_addr = m_addr + (m_addr[22] ? 32'd4 : 32'd1);
    @(negedge clk);
    wr = 0; rd = 0;
    if (r) check(t, rdata, exp);
  endtask

  task automatic set_addr(logic [31:0] a);
    op(0, 1, 0, a[15:0]);
    op(1, 1, 0, a[31:16]);
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < DSD; i++) m_ds[i] = 0;
    for (int i = 0; i < ISD; i++) m_is[i] = 0;
    m_addr = 0; m_lo = 0; m_inc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1", rdata, 16'd0);
    op(0, 0, 1, 0); op(1, 0, 1, 0); op(5, 0, 1, 0); op(2, 0, 1, 0);
    check("R1", m_addr[15:0], 16'd0);

    // R3 data write/read, R5 data step
    op(5, 1, 0, 16'd1);
    op(2, 1, 0, 16'hA001); op(2, 1, 0, 16'hA002);
    op(0, 0, 1, 0);
    set_addr(0); op(2, 0, 1, 0); op(2, 0, 1, 0);
    // R7 read-and-clear, then revisit the location
    set_addr(0); op(4, 0, 1, 0); set_addr(0); op(2, 0, 1, 0);
    op(4, 1, 0, 16'hFFFF); op(0, 0, 1, 0);
    // R6 staged low half not visible until the high write; R4 commit
    set_addr(32'h0040_0008);
    op(3, 1, 0, 16'h1234); op(0, 0, 1, 0); op(3, 0, 1, 0);
    op(2, 1, 0, 16'h5678); op(0, 0, 1, 0);
    set_addr(32'h0040_0008); op(3, 0, 1, 0); op(2, 0, 1, 0);
    op(4, 0, 1, 0);
    // R8 boundaries
    set_addr(DSD - 1); op(2, 1, 0, 16'hBEEF); op(2, 1, 0, 16'hDEAD);
    set_addr(DSD - 1); op(2, 0, 1, 0); op(2, 0, 1, 0);
    set_addr(32'h0040_0000 | (ISD * 4)); op(3, 1, 0, 1); op(2, 1, 0, 2);
    set_addr(32'h0040_0000 | (ISD * 4)); op(2, 0, 1, 0);
    set_addr(32'h00C0_0000); op(2, 0, 1, 0);
    // R9 read and write together, then idle hold
    set_addr(5); op(2, 1, 1, 16'h7777); set_addr(5); op(2, 0, 1, 0);
    op(0, 0, 1, 0);
    held = rdata;
    repeat (4) @(negedge clk);
    check("R9", rdata, held);
    op(6, 1, 1, 16'h1111); op(7, 0, 1, 0);

    for (int k = 0; k < 4000; k++) begin
      int s, pick;
      bit w, r;
      pick = $urandom_range(0, 99);
      if (pick < 8) begin
        case ($urandom_range(0, 4))
          0: set_addr(32'($urandom_range(0, 20)));
          1: set_addr(32'($urandom_range(DSD - 4, DSD + 2)));
          2: set_addr(32'h0040_0000 | 32'($urandom_range(0, 20) * 4));
          3: set_addr(32'h0040_0000 | 32'($urandom_range(ISD - 3, ISD + 1) * 4));
          default: set_addr(32'h0080_0000 | 32'($urandom_range(0, 9)));
        endcase
      end else begin
        s = (pick < 14) ? 5 : (pick < 60) ? 2 : (pick < 75) ? 3 :
            (pick < 87) ? 4 : (pick < 95) ? 0 : $urandom_range(0, 7);
        w = 1'($urandom_range(0, 1));
        r = 1'($urandom_range(0, 2) != 0);
        if (s == 0 || s == 1) w = 0;
        op(s, w, r, 16'($urandom()));
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule